// File: doc/BRIEF.md
# Clock-Select Pin Bus with Shared Serial EEPROM Access

This block owns a four-bit bus of clock-select pins that tells an external clock synthesizer which frequency to produce. Software programs the selection through a small register port. Parts of the selection are also visible at two other register addresses kept for compatibility. Writing any of these addresses changes the one shared copy of the selection.

The lower three pins can also be lent to a serial configuration EEPROM. When software sets an enable bit, one pin becomes an input carrying the EEPROM's data output. A second pin carries a software-written data bit to the EEPROM. The third carries a software-written shift clock. A separate pin gives the chip select. Software runs the whole serial protocol by toggling the bits through the register port, so the block holds no protocol timing. The top pin keeps its clock-select value in both modes.

All pin outputs are registered, and so is the read data. The EEPROM data input passes through a synchronizer before it can be read.

Top module: `clksel_pin_mux`

## Requirements
- R1: After a synchronous reset, every stored bit is 0. `csel_o` is 0, `csel_oe` is 4'b1111, `eep_cs_o` is 0 and `reg_rdata` is 0.
- R2: A write to address 0 stores `reg_wdata[3:0]` as the 4-bit clock selection. A read of address 0 returns the selection in bits 3:0 and 0 in bits 7:4. With EEPROM mode off, `csel_o` equals the selection one clock after it was stored.
- R3: Address 1 is the compatibility output register. Its bits 3:2 are the same storage as selection bits 1:0. Its bits 7:4 and 1:0 are plain storage. Writing either address 0 or address 1 updates both views.
- R4: At address 2, bit 5 is the same storage as selection bit 2. The other bits of address 2 read 0, and writing them has no effect.
- R5: Address 3 is the EEPROM control register. Bit 0 is the data bit, bit 1 the chip select, bit 2 the function enable and bit 3 the shift clock. Bits 7:4 read 0.
- R6: With the enable set, `csel_o[1]` carries the data bit and `csel_o[2]` carries the shift clock. `csel_oe[0]` is 0 and `csel_o[0]` is 0. `csel_o[3]` and `csel_oe[3:1]` still carry selection bit 3 and 1.
- R7: `eep_cs_o` is the chip-select bit when the enable is set. It is 0 whenever the enable is clear.
- R8: With the enable set, bit 0 read at address 3 returns the level of `csel0_i` after two synchronizer stages. A level held for 4 clocks is visible on the read. With the enable clear, the bit returns the stored data bit.
- R9: Clearing the enable returns `csel_o` to the full stored selection one clock later. No selection bit is lost while in EEPROM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| csel0_i | input | 1 | Level on pin 0, the EEPROM data output |
| csel_o | output | 4 | Pin output values |
| csel_oe | output | 4 | Pin output enables |
| eep_cs_o | output | 1 | EEPROM chip select |

## Verification
The bench sweeps every selection value and every byte at the two alias addresses. This catches a design that keeps separate copies, which would show a stale value at one address after a write to another. It also catches a mis-wired alias bit, which would move the wrong selection bit. Every EEPROM control combination is crossed with both input levels. This exposes a swapped data or shift-clock pin, a chip select that leaks while the enable is clear, and pin 0 left driven in EEPROM mode. It also exposes readback of the stored data bit in place of the pin level. A final return to clock-select mode shows whether the top selection bit or the lent bits were lost.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 2;
  localparam int CSEL_W  = 4;

  localparam logic [ADDR_W-1:0] A_CSEL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_MISC   = 2'd1;
  localparam logic [ADDR_W-1:0] A_LEGACY = 2'd2;
  localparam logic [ADDR_W-1:0] A_EECTL  = 2'd3;

  // alias positions
  localparam int MISC_LO    = 2;   // misc bits 3:2 <-> csel 1:0
  localparam int LEGACY_BIT = 5;   // legacy bit 5 <-> csel 2

  // pins lent to the EEPROM
  localparam int PIN_DI = 0;
  localparam int PIN_DO = 1;
  localparam int PIN_SK = 2;

  typedef struct packed {
    logic sck;
    logic en;
    logic cs;
    logic data;
  } ee_ctrl_t;
endpackage

// File: rtl/clksel_regfile.sv
module clksel_regfile
  import clksel_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [CSEL_W-1:0]   clksel,
  output logic [5:0]          misc_rest,
  output ee_ctrl_t            ee
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clksel    <= '0;
      misc_rest <= '0;
      ee        <= '0;
    end else if (we) begin
      case (addr)
        A_CSEL:   clksel <= wdata[CSEL_W-1:0];
        A_MISC: begin
          clksel[1:0] <= wdata[MISC_LO+1:MISC_LO];
          misc_rest   <= {wdata[7:4], wdata[1:0]};
        end
        A_LEGACY: clksel[2] <= wdata[LEGACY_BIT];
        default:  ee <= ee_ctrl_t'(wdata[3:0]);
      endcase
    end
  end

  // R3
  misc_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_MISC) |=> (clksel[1:0] == $past(wdata[3:2])));

  // R4
  legacy_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_LEGACY) |=> (clksel[2] == $past(wdata[5]) && clksel[3] == $past(clksel[3])));
endmodule

// File: rtl/clksel_sync.sv
module clksel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_pin_drv.sv
module clksel_pin_drv
  import clksel_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CSEL_W-1:0]  clksel,
  input  ee_ctrl_t           ee,
  output logic [CSEL_W-1:0]  csel_o,
  output logic [CSEL_W-1:0]  csel_oe,
  output logic               eep_cs_o
);
  logic [CSEL_W-1:0] nxt_o, nxt_oe;

  always_comb begin
    nxt_o  = clksel;
    nxt_oe = '1;
    if (ee.en) begin
      nxt_o[PIN_DI]  = 1'b0;
      nxt_oe[PIN_DI] = 1'b0;
      nxt_o[PIN_DO]  = ee.data;
      nxt_o[PIN_SK]  = ee.sck;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csel_o   <= '0;
      csel_oe  <= '1;
      eep_cs_o <= 1'b0;
    end else begin
      csel_o   <= nxt_o;
      csel_oe  <= nxt_oe;
      eep_cs_o <= ee.en & ee.cs;
    end
  end

  // R6
  ee_pins_chk: assert property (@(posedge clk) disable iff (rst)
    ee.en |=> (csel_o[PIN_SK] == $past(ee.sck) && csel_o[PIN_DO] == $past(ee.data)
               && !csel_oe[PIN_DI] && csel_o[CSEL_W-1] == $past(clksel[CSEL_W-1])));

  // R7
  cs_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ee.en |=> !eep_cs_o);

  // R9
  normal_pins_chk: assert property (@(posedge clk) disable iff (rst)
    !ee.en |=> (csel_o == $past(clksel) && csel_oe == '1));
endmodule

// File: rtl/clksel_pin_mux.sv
module clksel_pin_mux
  import clksel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              csel0_i,
  output logic [3:0]        csel_o,
  output logic [3:0]        csel_oe,
  output logic              eep_cs_o
);
  logic [CSEL_W-1:0] clksel;
  logic [5:0]        misc_rest;
  ee_ctrl_t          ee;
  logic              di_sync;
  logic [REG_W-1:0]  rd_nxt;

  clksel_regfile u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .clksel(clksel), .misc_rest(misc_rest), .ee(ee)
  );

  clksel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(csel0_i), .q(di_sync)
  );

  clksel_pin_drv u_pins (
    .clk(clk), .rst(rst), .clksel(clksel), .ee(ee),
    .csel_o(csel_o), .csel_oe(csel_oe), .eep_cs_o(eep_cs_o)
  );

  always_comb begin
    rd_nxt = '0;
    case (reg_addr)
      A_CSEL:   rd_nxt[CSEL_W-1:0] = clksel;
      A_MISC:   rd_nxt = {misc_rest[5:2], clksel[1:0], misc_rest[1:0]};
      A_LEGACY: rd_nxt[LEGACY_BIT] = clksel[2];
      default:  rd_nxt[3:0] = {ee.sck, ee.en, ee.cs, ee.en ? di_sync : ee.data};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end

  // R5
  ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_EECTL) |=> (reg_rdata[7:4] == 4'd0));

  // R8
  di_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_EECTL && ee.en && !reg_we) |=> (reg_rdata[0] == $past(di_sync)));
endmodule

// File: tb/clksel_pin_mux_bench.sv
module clksel_pin_mux_bench;
  logic clk = 1'b0;
  logic rst;
  logic we;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic di;
  logic [3:0] pins, oe;
  logic cs_pin;

  int total = 0;
  int bad = 0;
  logic [3:0] m_sel;
  logic [5:0] m_rest;
  logic [7:0] v;

  always #10 clk = ~clk;

  clksel_pin_mux u_clksel_pin_mux (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .csel0_i(di), .csel_o(pins), .csel_oe(oe), .eep_cs_o(cs_pin)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; we = 1'b0; addr = 2'd0; wdata = 8'd0; di = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", {28'd0, pins}, 32'h0);
    check("R1 oe", {28'd0, oe}, 32'hF);
    check("R1 cs", {31'd0, cs_pin}, 32'h0);
    check("R1 rdata", {24'd0, rdata}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 regs", {24'd0, v}, 32'h0);
    end
    m_sel = 4'd0; m_rest = 6'd0;

    // R2 selection sweep with alias views
    for (int s = 0; s < 16; s++) begin
      wr(2'd0, {4'hA, s[3:0]});
      m_sel = s[3:0];
      rd(2'd0, v);
      check("R2 readback", {24'd0, v}, {28'd0, m_sel});
      check("R2 pins", {28'd0, pins}, {28'd0, m_sel});
      check("R2 oe", {28'd0, oe}, 32'hF);
      rd(2'd1, v);
      check("R3 view of sel", {30'd0, v[3:2]}, {30'd0, m_sel[1:0]});
      rd(2'd2, v);
      check("R4 view of sel", {24'd0, v}, {26'd0, m_sel[2], 5'd0});
    end

    // R3 compatibility address sweep
    for (int d = 0; d < 256; d++) begin
      wr(2'd1, d[7:0]);
      m_sel[1:0] = d[3:2];
      m_rest = {d[7:4], d[1:0]};
      rd(2'd1, v);
      check("R3 misc readback", {24'd0, v}, {24'd0, d[7:0]});
      rd(2'd0, v);
      check("R3 sel view", {24'd0, v}, {28'd0, m_sel});
    end

    // R4 legacy address sweep
    for (int d = 0; d < 256; d++) begin
      wr(2'd2, d[7:0]);
      m_sel[2] = d[5];
      rd(2'd2, v);
      check("R4 legacy readback", {24'd0, v}, {26'd0, d[5], 5'd0});
      rd(2'd0, v);
      check("R4 sel view", {24'd0, v}, {28'd0, m_sel});
    end
    rd(2'd1, v);
    check("R3 rest kept", {24'd0, v}, {24'd0, m_rest[5:2], m_sel[1:0], m_rest[1:0]});

    // EEPROM mode sweep: ctl bit0 data, bit1 cs, bit2 en, bit3 sck
    wr(2'd0, 8'h0D);
    m_sel = 4'hD;
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 2; p++) begin
        wr(2'd3, {4'hF, c[3:0]});
        di = p[0];
        repeat (4) @(negedge clk);
        rd(2'd3, v);
        check("R5 ctl fields", {24'd0, v[7:1]}, {28'd0, c[3:1]});
        check("R8 data read", {31'd0, v[0]}, {31'd0, c[2] ? p[0] : c[0]});
        check("R7 chip select", {31'd0, cs_pin}, {31'd0, c[2] & c[1]});
        if (c[2]) begin
          check("R6 pins", {28'd0, pins}, {28'd0, m_sel[3], c[3], c[0], 1'b0});
          check("R6 oe", {28'd0, oe}, 32'hE);
        end else begin
          check("R9 pins normal", {28'd0, pins}, {28'd0, m_sel});
          check("R9 oe normal", {28'd0, oe}, 32'hF);
        end
      end
    end

    // R9 selection survives EEPROM mode, including writes during it
    wr(2'd3, 8'h0E);
    wr(2'd0, 8'h06);
    m_sel = 4'h6;
    @(negedge clk);
    check("R6 sel3 during ee", {31'd0, pins[3]}, 32'h0);
    wr(2'd3, 8'h00);
    @(negedge clk);
    check("R9 restored", {28'd0, pins}, 32'h6);
    check("R9 cs off", {31'd0, cs_pin}, 32'h0);

    // R1 reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 re-reset pins", {28'd0, pins}, 32'h0);
    rd(2'd1, v);
    check("R1 re-reset misc", {24'd0, v}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule